// File: doc/BRIEF.md
# Page-granular memory protection checker

This block watches a stream of processor memory accesses and checks each one against four guarded pages. Each page is 1024 bytes, and each has its own two-bit permission code. An access that lands in a guarded page without the right it needs is a violation. A violation sets that page's pending flag and records the faulting address. It also raises an interrupt line, which is gated by a per-page mask and a global enable.

Software reaches the block through a 16-bit register port. Writes take effect at the clock edge. Reads are combinational from the register offset. The block only reports violations. It never stalls, blocks or aborts the access it observes.

Top module: `mem_guard`

## Requirements
- R1: After reset, every page address reads 0, the permission register at 0x10 reads 0x00FF, and the mask (0x1C), flags (0x1E), status (0x20) and both fault registers (0x22, 0x24) read 0. The `irq` output is low.
- R2: Page N is programmed at two offsets. Offset 4N holds address bits 15..0 and offset 4N+2 holds address bits 31..16. Both read back as written. An access matches page N when address bits 31..10 equal the programmed bits 31..10.
- R3: The permission code governs a matching access as follows: 00 faults on reads and writes, 01 faults on writes only, 10 faults on reads only, and 11 never faults.
- R4: A violation of page N sets flag bit N at 0x1E on the next clock edge. When one access violates several pages, all of their flags are set.
- R5: At 0x1E, writing 1 to bit N clears flag N and writing 0 leaves it. A violation in the same cycle as a clear leaves the flag set. Bit 4 reads as the OR of bits 3..0 and is not writable.
- R6: `irq` is high exactly when mask bit 4 is set and some flag bit N is set together with mask bit N. Flags are still recorded while masked.
- R7: Status bit 1 at 0x20 is set on the clock edge after a cycle in which `irq` is high. Writing 1 to it clears it, unless `irq` is still high, in which case it stays set. Other status bits read 0.
- R8: On a violation, 0x22 captures address bits 15..5 in bits 15..5, and 0x24 captures address bits 29..16 in bits 13..0. All other bits read 0. The most recent violation overwrites the previous capture.
- R9: In the register at 0x10, page N's code sits in bits [2N+1:2N], and bits 15..8 read 0.
- R10: A cycle with `acc_valid` low never sets a flag or changes the fault registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | An access is present this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 32 | Byte address of the access |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The visible effects of internal faults arrive with different delays:

- A corrupted page address or permission code shows up one cycle after the first access to the affected page. The pending flag is either missing or set wrongly at 0x1E.
- A flag that is set but masked appears on `irq` as soon as its mask and the global enable are both set, with no register in between.
- A stale fault capture shows on the next read of 0x22 or 0x24 after a violation.
- A wrong status bit lags `irq` by exactly one cycle.

The bench therefore reads the registers right after each access and compares them with values it predicts from the address and the codes it has programmed.

// File: rtl/mg_pkg.sv
package mg_pkg;
  localparam int ADDR_W    = 32;
  localparam int DATA_W    = 16;
  localparam int REG_AW    = 6;
  localparam int PAGE_BITS = 10;
  localparam int LO_LSB    = 5;
  localparam int HI_LSB    = 16;
  localparam int HI_MSB    = 29;

  localparam logic [REG_AW-1:0] OFS_TYPE   = 6'h10;
  localparam logic [REG_AW-1:0] OFS_MASK   = 6'h1C;
  localparam logic [REG_AW-1:0] OFS_FLAG   = 6'h1E;
  localparam logic [REG_AW-1:0] OFS_STAT   = 6'h20;
  localparam logic [REG_AW-1:0] OFS_FLT_LO = 6'h22;
  localparam logic [REG_AW-1:0] OFS_FLT_HI = 6'h24;

  typedef logic [1:0] perm_t;
  localparam perm_t PERM_FULL = 2'b11;
endpackage

// File: rtl/mg_region_chk.sv
module mg_region_chk #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid_i,
  input  logic                    acc_write_i,
  input  logic [ADDR_W-1:PAGE_BITS] acc_page_i,
  input  logic [ADDR_W-1:PAGE_BITS] page_i,
  input  mg_pkg::perm_t           code_i,
  output logic                    viol_o
);
  logic hit;
  logic allowed;

  always_comb begin
    hit     = acc_valid_i && (acc_page_i == page_i);
    allowed = acc_write_i ? code_i[1] : code_i[0];
    viol_o  = hit && !allowed;
  end

  // R3: full access never faults
  assert_full_never_faults_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == mg_pkg::PERM_FULL) |-> !viol_o);
  // R10: nothing without a valid access
  assert_idle_no_fault_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid_i |-> !viol_o);
endmodule

// File: rtl/mg_irq_ctrl.sv
module mg_irq_ctrl #(
  parameter int NUM_RGN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_RGN-1:0] viol_i,
  input  logic [NUM_RGN-1:0] clr_i,
  input  logic [NUM_RGN:0]   mask_i,
  input  logic               st_clr_i,
  output logic [NUM_RGN-1:0] flag_o,
  output logic               status_o,
  output logic               irq_o
);
  logic [NUM_RGN-1:0] flag_q, flag_d;
  logic               status_q, status_d;
  logic               irq_c;

  always_comb begin
    flag_d   = (flag_q & ~clr_i) | viol_i;
    irq_c    = mask_i[NUM_RGN] && |(flag_q & mask_i[NUM_RGN-1:0]);
    status_d = irq_c ? 1'b1 : (status_q && !st_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= '0;
      status_q <= 1'b0;
    end else begin
      flag_q   <= flag_d;
      status_q <= status_d;
    end
  end

  assign flag_o   = flag_q;
  assign status_o = status_q;
  assign irq_o    = irq_c;

  for (genvar i = 0; i < NUM_RGN; i++) begin : g_chk
    // R4: a violation leaves its flag set, even against a clear
    assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      viol_i[i] |=> flag_o[i]);
    // R5: clear without a new violation empties the flag
    assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !viol_i[i]) |=> !flag_o[i]);
  end

  // R7: status follows an asserted interrupt
  assert_status_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> status_o);
endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mg_pkg::*;
#(
  parameter int NUM_RGN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int TYPE_W = 2 * NUM_RGN;
  localparam int LO_W   = 16 - LO_LSB;
  localparam int HI_W   = HI_MSB - HI_LSB + 1;

  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [ADDR_W-1:0]  page_q [NUM_RGN];
  logic [ADDR_W-1:0]  page_d [NUM_RGN];
  logic [TYPE_W-1:0]  type_q, type_d;
  logic [NUM_RGN:0]   mask_q, mask_d;
  logic [LO_W-1:0]    flt_lo_q, flt_lo_d;
  logic [HI_W-1:0]    flt_hi_q, flt_hi_d;
  logic [NUM_RGN-1:0] viol;
  logic [NUM_RGN-1:0] flag;
  logic [NUM_RGN-1:0] flag_clr;
  logic               status;
  logic               st_clr;
  logic               any_viol;
  logic               addr_unused;

  assign addr_unused = ^acc_addr[LO_LSB-1:0];

  for (genvar n = 0; n < NUM_RGN; n++) begin : g_rgn
    mg_region_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) i_chk (
      .clk        (clk),
      .rst_n      (rst_sync),
      .acc_valid_i(acc_valid),
      .acc_write_i(acc_write),
      .acc_page_i (acc_addr[ADDR_W-1:PAGE_BITS]),
      .page_i     (page_q[n][ADDR_W-1:PAGE_BITS]),
      .code_i     (type_q[2*n+1:2*n]),
      .viol_o     (viol[n])
    );
  end

  assign any_viol = |viol;
  assign flag_clr = (reg_we && reg_addr == OFS_FLAG) ? reg_wdata[NUM_RGN-1:0] : '0;
  assign st_clr   = reg_we && (reg_addr == OFS_STAT) && reg_wdata[1];

  mg_irq_ctrl #(.NUM_RGN(NUM_RGN)) i_irq (
    .clk     (clk),
    .rst_n   (rst_sync),
    .viol_i  (viol),
    .clr_i   (flag_clr),
    .mask_i  (mask_q),
    .st_clr_i(st_clr),
    .flag_o  (flag),
    .status_o(status),
    .irq_o   (irq)
  );

  always_comb begin
    for (int n = 0; n < NUM_RGN; n++) begin
      page_d[n] = page_q[n];
      if (reg_we && int'(reg_addr) == 4 * n)     page_d[n][15:0]  = reg_wdata;
      if (reg_we && int'(reg_addr) == 4 * n + 2) page_d[n][31:16] = reg_wdata;
    end
    type_d   = (reg_we && reg_addr == OFS_TYPE) ? reg_wdata[TYPE_W-1:0] : type_q;
    mask_d   = (reg_we && reg_addr == OFS_MASK) ? reg_wdata[NUM_RGN:0]  : mask_q;
    flt_lo_d = any_viol ? acc_addr[15:LO_LSB]     : flt_lo_q;
    flt_hi_d = any_viol ? acc_addr[HI_MSB:HI_LSB] : flt_hi_q;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      for (int n = 0; n < NUM_RGN; n++) page_q[n] <= '0;
      type_q   <= '1;
      mask_q   <= '0;
      flt_lo_q <= '0;
      flt_hi_q <= '0;
    end else begin
      for (int n = 0; n < NUM_RGN; n++) page_q[n] <= page_d[n];
      type_q   <= type_d;
      mask_q   <= mask_d;
      flt_lo_q <= flt_lo_d;
      flt_hi_q <= flt_hi_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int n = 0; n < NUM_RGN; n++) begin
      if (int'(reg_addr) == 4 * n)     reg_rdata = page_q[n][15:0];
      if (int'(reg_addr) == 4 * n + 2) reg_rdata = page_q[n][31:16];
    end
    case (reg_addr)
      OFS_TYPE:   reg_rdata = DATA_W'(type_q);
      OFS_MASK:   reg_rdata = DATA_W'(mask_q);
      OFS_FLAG:   reg_rdata = DATA_W'({|flag, flag});
      OFS_STAT:   reg_rdata = DATA_W'({status, 1'b0});
      OFS_FLT_LO: reg_rdata = {flt_lo_q, {LO_LSB{1'b0}}};
      OFS_FLT_HI: reg_rdata = DATA_W'(flt_hi_q);
      default: ;
    endcase
  end

  // R8: a violation captures its address fields
  assert_fault_capture_R8: assert property (@(posedge clk) disable iff (!rst_sync)
    any_viol |=> (flt_lo_q == $past(acc_addr[15:LO_LSB]) &&
                  flt_hi_q == $past(acc_addr[HI_MSB:HI_LSB])));
  // R10: fault registers hold without a violation
  assert_fault_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync)
    !any_viol |=> ($stable(flt_lo_q) && $stable(flt_hi_q)));
  // R6: interrupt never raised without global enable
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_sync)
    irq |-> mask_q[NUM_RGN]);
endmodule

// File: tb/test_mem_guard.sv
module test_mem_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mem_guard i_mem_guard (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic access(input logic [31:0] a, input logic w);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [5:0] a, input logic [15:0] e);
    logic [15:0] v;
    rd(a, v);
    check(req, {16'h0, v}, {16'h0, e});
  endtask

  task automatic t_reset;
    for (int n = 0; n < 8; n++) expect_reg("R1 page", 6'(2 * n), 16'h0000);
    expect_reg("R1 type", 6'h10, 16'h00FF);
    expect_reg("R1 mask", 6'h1C, 16'h0000);
    expect_reg("R1 flag", 6'h1E, 16'h0000);
    expect_reg("R1 stat", 6'h20, 16'h0000);
    expect_reg("R1 flo", 6'h22, 16'h0000);
    expect_reg("R1 fhi", 6'h24, 16'h0000);
    check("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_page_match;
    wr(6'h00, 16'h2400); wr(6'h02, 16'h0001);
    expect_reg("R2 lo half", 6'h00, 16'h2400);
    expect_reg("R2 hi half", 6'h02, 16'h0001);
    wr(6'h10, 16'h00FC);
    expect_reg("R9 type layout", 6'h10, 16'h00FC);
    access(32'h0001_27FC, 1'b0);
    expect_reg("R2 hit top of page", 6'h1E, 16'h0011);
    expect_reg("R8 lo", 6'h22, 16'h27E0);
    expect_reg("R8 hi", 6'h24, 16'h0001);
    check("R6 masked irq", {31'h0, irq}, 32'h0);
    wr(6'h1E, 16'h0001);
    access(32'h0001_2800, 1'b0);
    access(32'h0001_23FF, 1'b1);
    expect_reg("R2 outside page", 6'h1E, 16'h0000);
  endtask

  task automatic t_perm;
    wr(6'h04, 16'h0000); wr(6'h06, 16'h0004);
    wr(6'h10, 16'h00F4);
    access(32'h0004_0010, 1'b0);
    expect_reg("R3 01 read ok", 6'h1E, 16'h0000);
    access(32'h0004_0010, 1'b1);
    expect_reg("R3 01 write faults", 6'h1E, 16'h0012);
    wr(6'h1E, 16'h0002);
    wr(6'h10, 16'h00F8);
    access(32'h0004_0020, 1'b1);
    expect_reg("R3 10 write ok", 6'h1E, 16'h0000);
    access(32'h0004_0020, 1'b0);
    expect_reg("R3 10 read faults", 6'h1E, 16'h0012);
    wr(6'h1E, 16'h0002);
    wr(6'h10, 16'h00FC);
    access(32'h0004_0030, 1'b0);
    access(32'h0004_0030, 1'b1);
    expect_reg("R3 11 never faults", 6'h1E, 16'h0000);
  endtask

  task automatic t_w1c;
    access(32'h0001_2400, 1'b1);
    wr(6'h1E, 16'h0010);
    expect_reg("R5 write 0 and bit4 keep", 6'h1E, 16'h0011);
    wr(6'h1E, 16'h0001);
    expect_reg("R5 write 1 clears", 6'h1E, 16'h0000);
    access(32'h0001_2400, 1'b1);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 32'h0001_2404;
    reg_we = 1'b1; reg_addr = 6'h1E; reg_wdata = 16'h0001;
    @(negedge clk);
    acc_valid = 1'b0; reg_we = 1'b0;
    expect_reg("R5 set wins", 6'h1E, 16'h0011);
  endtask

  task automatic t_irq;
    wr(6'h1C, 16'h0001);
    check("R6 no global", {31'h0, irq}, 32'h0);
    wr(6'h1C, 16'h0012);
    check("R6 other region masked", {31'h0, irq}, 32'h0);
    wr(6'h1C, 16'h0011);
    check("R6 enabled", {31'h0, irq}, 32'h1);
    @(negedge clk);
    expect_reg("R7 status set", 6'h20, 16'h0002);
    wr(6'h20, 16'h0002);
    expect_reg("R7 held while irq", 6'h20, 16'h0002);
    wr(6'h1E, 16'h0001);
    check("R6 cleared", {31'h0, irq}, 32'h0);
    wr(6'h20, 16'h0002);
    expect_reg("R7 status cleared", 6'h20, 16'h0000);
    wr(6'h1C, 16'h0000);
  endtask

  task automatic t_overlap;
    wr(6'h08, 16'h8000); wr(6'h0A, 16'h0020);
    wr(6'h0C, 16'h8000); wr(6'h0E, 16'h0020);
    wr(6'h10, 16'h000F);
    access(32'h0020_8040, 1'b0);
    access(32'h0020_8360, 1'b1);
    expect_reg("R4 both flags", 6'h1E, 16'h001C);
    expect_reg("R8 last lo", 6'h22, 16'h8360);
    expect_reg("R8 last hi", 6'h24, 16'h0020);
    wr(6'h1E, 16'h000F);
  endtask

  task automatic t_idle;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_addr = 32'h0020_8100;
    @(negedge clk);
    @(negedge clk);
    expect_reg("R10 no flag", 6'h1E, 16'h0000);
    expect_reg("R10 lo kept", 6'h22, 16'h8360);
  endtask

  task automatic t_field_edges;
    wr(6'h00, 16'hFC00); wr(6'h02, 16'hFFFF);
    wr(6'h10, 16'h00FC);
    access(32'hFFFF_FFFF, 1'b1);
    expect_reg("R8 lo edge", 6'h22, 16'hFFE0);
    expect_reg("R8 hi edge", 6'h24, 16'h3FFF);
    expect_reg("R4 edge flag", 6'h1E, 16'h0011);
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_page_match();
    t_perm();
    t_w1c();
    t_irq();
    t_overlap();
    t_idle();
    t_field_edges();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule